// File: doc/BRIEF.md
# Resonant period calibration engine

This block measures the mechanical resonance period of a linear actuator. The period is counted in enabled cycles of the PWM input clock. A start request launches a calibration event. First comes a drive stage of one to eight nominal periods. A settling delay, derived from the nominal divisor, follows. After the delay the block watches a 1-bit back-EMF comparator and looks for four debounced zero crossings.

A zero crossing is debounced by accumulation. Samples that disagree with the last accepted level are counted, isolated disagreements included. A crossing is declared when that count reaches a programmed threshold. The block records when each of the four crossings happens. It forms two period estimates, one from crossings 1 and 3 and one from crossings 2 and 4. It then picks either the first estimate or the mean of both.

The chosen result is accepted only if it lies within a shift-based percentage band around the nominal divisor. An accepted result can be kept and used as the starting divisor of later events. A rejected result, or a run that times out, leaves the previous divisor in place. The block has no bus interface: configuration arrives on plain inputs, and results and status leave on plain outputs.

Top module: `lra_period_cal`

## Requirements
- R1: After reset `state_code` is 0 (idle), `div_final`, `est_a`, `est_b`, `first_tag`, `cal_fail`, `drive_on` and `last_level` are 0, and `first_since_por` is 1.
- R2: With `cfg_cal_en` low, a start moves straight to state 8 (done) on the next clock. No drive or measurement takes place, the estimates and `first_tag` read 0, and `div_final` takes the event's base divisor.
- R3: With `cfg_cal_en` high, a start enters state 1 (drive). `drive_on` is high for exactly (`cfg_pulse_num`+1) x `cfg_nom_div` enabled ticks.
- R4: After the drive stage the block waits `cfg_nom_div` >> (3+`cfg_delay_sel`) enabled ticks, then opens the seek window. Drive, delay and seek advance only on clocks with `pwm_tick` high.
- R5: On the tick that opens the seek window, the detector level is loaded from `cmp_in`. During the seek window, each enabled sample that differs from the level adds one to a count. When the count reaches `cfg_zx_thr` (0 acts as 1), a crossing is declared, the level flips and the count clears. `last_level` shows the level.
- R6: Crossing times are seek-tick indices, with the first seek tick at index 0. `first_tag` is the time of crossing 1, `est_a` is time 3 minus time 1, and `est_b` is time 4 minus time 2. Both estimates saturate at the all-ones value.
- R7: If the fourth crossing is not declared within 3 x `cfg_nom_div` seek ticks, the state becomes 9 (fail) and `cal_fail` goes high. `div_final` keeps the base divisor. A fourth crossing on the last tick of the window still counts as success.
- R8: With `cfg_avg_sel` low the result is `est_a`. With it high the result is (`est_a`+`est_b`)>>1, and the carry of the sum is kept.
- R9: A `cfg_margin` of 0 accepts any result. Codes 1 to 7 accept a result when |result - nominal| <= nominal >> (9-code). Codes 8 to 15 act as code 7. An accepted result is loaded into `div_final`, and a rejected one leaves it unchanged. Either way the state ends at 8.
- R10: The base divisor of an event is the last accepted result when `cfg_keep_en` is high and a result has been kept, and `cfg_nom_div` otherwise. A result is kept only when it is accepted while `cfg_keep_en` is high.
- R11: `first_since_por` stays 1 until the first calibration run after reset finishes, by success, rejection or failure. A start with `cfg_cal_en` low does not clear it.
- R12: A start is taken only in states 0, 8 and 9. A start during a run has no effect.
- R13: State codes are 0 idle, 1 drive, 2 delay, 3 to 6 seek for crossings 1 to 4, 7 compute, 8 done and 9 fail. Compute lasts exactly one clock and is followed by done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_tick | input | 1 | Enable marking one PWM input clock period |
| cmp_in | input | 1 | Back-EMF comparator sample |
| start | input | 1 | Starts a calibration event |
| cfg_cal_en | input | 1 | Perform measurement when high |
| cfg_pulse_num | input | PULSE_W | Drive pulses minus one |
| cfg_delay_sel | input | 2 | Settling delay shift select |
| cfg_zx_thr | input | THR_W | Crossing accumulation threshold |
| cfg_avg_sel | input | 1 | Result is mean of both estimates |
| cfg_margin | input | 4 | Acceptance band code |
| cfg_keep_en | input | 1 | Keep accepted result for later events |
| cfg_nom_div | input | DIV_W | Nominal divisor |
| drive_on | output | 1 | Drive stage active |
| div_final | output | DIV_W | Divisor in force |
| est_a | output | DIV_W | Estimate from crossings 1 and 3 |
| est_b | output | DIV_W | Estimate from crossings 2 and 4 |
| first_tag | output | DIV_W+2 | Time of crossing 1 |
| cal_fail | output | 1 | Seek window timed out |
| state_code | output | 4 | Sequencer state |
| last_level | output | 1 | Last accepted comparator level |
| first_since_por | output | 1 | No calibration run finished since reset |

## Verification
Two situations are hard to reach from the ports. The first is a timeout that coincides with the fourth crossing on the last tick of the window. The second is an early crossing caused by glitches that the accumulating count has built up. Both depend on the exact seek-tick index at which each comparator sample lands. The stimulus therefore defines the comparator waveform as a function of the enabled-tick count since start, so the alignment holds regardless of how sparse `pwm_tick` is. A periodic glitch pattern is then overlaid, and thresholds, phases, delays and pulse counts are swept, so that crossings shift around the window edges.

// File: rtl/lra_cal_pkg.sv
package lra_cal_pkg;

   typedef enum logic [3:0] {
      CS_IDLE    = 4'd0,
      CS_DRIVE   = 4'd1,
      CS_DELAY   = 4'd2,
      CS_SEEK1   = 4'd3,
      CS_SEEK2   = 4'd4,
      CS_SEEK3   = 4'd5,
      CS_SEEK4   = 4'd6,
      CS_COMPUTE = 4'd7,
      CS_DONE    = 4'd8,
      CS_FAIL    = 4'd9
   } cal_state_e;

   localparam int unsigned CROSS_CNT = 4;
   localparam logic [3:0]  SHIFT_BASE = 4'd9;

   // band codes above 7 behave as the widest band
   function automatic logic [2:0] band_code(input logic [3:0] code);
      return (code > 4'd7) ? 3'd7 : code[2:0];
   endfunction

endpackage

// File: rtl/lra_zc_detect.sv
module lra_zc_detect #(
   parameter int THR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             load_val,
   input  logic             sample_en,
   input  logic             cmp,
   input  logic [THR_W-1:0] thr,
   output logic             hit,
   output logic             level
);

   logic [THR_W-1:0] acc_q;
   logic             lvl_q;
   logic [THR_W:0]   need;
   logic [THR_W:0]   got;
   logic             differ;

   always_comb begin
      need   = (thr == '0) ? {{THR_W{1'b0}}, 1'b1} : {1'b0, thr};
      got    = {1'b0, acc_q} + {{THR_W{1'b0}}, 1'b1};
      differ = (cmp != lvl_q);
      hit    = sample_en && differ && (got >= need);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         lvl_q <= 1'b0;
      end else if (load) begin
         acc_q <= '0;
         lvl_q <= load_val;
      end else if (sample_en && differ) begin
         if (got >= need) begin
            acc_q <= '0;
            lvl_q <= cmp;
         end else begin
            acc_q <= got[THR_W-1:0];
         end
      end
   end

   assign level = lvl_q;

endmodule

// File: rtl/lra_period_calc.sv
module lra_period_calc
   import lra_cal_pkg::*;
#(
   parameter int DIV_W   = 16,
   parameter int TAG_W   = 18,
   parameter bit SAT_EST = 1'b1
) (
   input  logic [3:0][TAG_W-1:0] tags,
   input  logic [DIV_W-1:0]      nom,
   input  logic                  avg_sel,
   input  logic [3:0]            margin,
   output logic [DIV_W-1:0]      est_a,
   output logic [DIV_W-1:0]      est_b,
   output logic [DIV_W-1:0]      result,
   output logic                  accept
);

   localparam logic [TAG_W-1:0] EST_MAX = {{(TAG_W-DIV_W){1'b0}}, {DIV_W{1'b1}}};

   logic [TAG_W-1:0] span_a;
   logic [TAG_W-1:0] span_b;
   logic [DIV_W:0]   sum_ab;
   logic [DIV_W-1:0] mean_ab;
   logic [3:0]       shamt;
   logic [DIV_W-1:0] tol;
   logic [DIV_W-1:0] dev;

   assign span_a = tags[2] - tags[0];
   assign span_b = tags[3] - tags[1];

   generate
      if (SAT_EST) begin : g_sat
         assign est_a = (span_a > EST_MAX) ? {DIV_W{1'b1}} : span_a[DIV_W-1:0];
         assign est_b = (span_b > EST_MAX) ? {DIV_W{1'b1}} : span_b[DIV_W-1:0];
      end else begin : g_wrap
         assign est_a = span_a[DIV_W-1:0];
         assign est_b = span_b[DIV_W-1:0];
      end
   endgenerate

   always_comb begin
      sum_ab  = {1'b0, est_a} + {1'b0, est_b};
      mean_ab = DIV_W'(sum_ab >> 1);
      result  = avg_sel ? mean_ab : est_a;
      shamt   = SHIFT_BASE - {1'b0, band_code(margin)};
      tol     = nom >> shamt;
      dev     = (result >= nom) ? (result - nom) : (nom - result);
      accept  = (margin == 4'd0) || (dev <= tol);
   end

endmodule

// File: rtl/lra_period_cal.sv
module lra_period_cal
   import lra_cal_pkg::*;
#(
   parameter int DIV_W   = 16,
   parameter int THR_W   = 8,
   parameter int PULSE_W = 3,
   parameter bit SAT_EST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pwm_tick,
   input  logic               cmp_in,
   input  logic               start,
   input  logic               cfg_cal_en,
   input  logic [PULSE_W-1:0] cfg_pulse_num,
   input  logic [1:0]         cfg_delay_sel,
   input  logic [THR_W-1:0]   cfg_zx_thr,
   input  logic               cfg_avg_sel,
   input  logic [3:0]         cfg_margin,
   input  logic               cfg_keep_en,
   input  logic [DIV_W-1:0]   cfg_nom_div,
   output logic               drive_on,
   output logic [DIV_W-1:0]   div_final,
   output logic [DIV_W-1:0]   est_a,
   output logic [DIV_W-1:0]   est_b,
   output logic [DIV_W+1:0]   first_tag,
   output logic               cal_fail,
   output logic [3:0]         state_code,
   output logic               last_level,
   output logic               first_since_por
);

   localparam int TAG_W = DIV_W + 2;
   localparam int CW    = DIV_W + PULSE_W + 1;

   generate
      if (DIV_W < 4) begin : g_bad_div
         $error("DIV_W must be at least 4");
      end
      if (THR_W < 1) begin : g_bad_thr
         $error("THR_W must be at least 1");
      end
      if (PULSE_W < 1) begin : g_bad_pulse
         $error("PULSE_W must be at least 1");
      end
   endgenerate

   cal_state_e             st_q;
   logic [CW-1:0]          cnt_q;
   logic [3:0][TAG_W-1:0]  tag_q;
   logic [DIV_W-1:0]       div_q;
   logic [DIV_W-1:0]       keep_q;
   logic                   keep_vld_q;
   logic                   fail_q;
   logic                   first_q;

   logic [CW-1:0]    nom_ext;
   logic [CW-1:0]    pulses_ext;
   logic [CW-1:0]    lim_drv;
   logic [CW-1:0]    lim_dly;
   logic [CW-1:0]    lim_seek;
   logic [CW-1:0]    cnt_inc;
   logic             drive_end;
   logic             delay_end;
   logic             dly_zero;
   logic             seek_tmo;
   logic             in_seek;
   logic             can_start;
   logic             take_start;
   logic [1:0]       seek_idx;
   cal_state_e       seek_next;
   logic [DIV_W-1:0] base_div;
   logic             zc_load;
   logic             zc_sample;
   logic             zc_hit;
   logic             zc_level;
   logic [DIV_W-1:0] calc_result;
   logic             calc_accept;

   // window lengths, all in enabled ticks
   always_comb begin
      nom_ext    = {{(CW-DIV_W){1'b0}}, cfg_nom_div};
      pulses_ext = {{(CW-PULSE_W){1'b0}}, cfg_pulse_num} + {{(CW-1){1'b0}}, 1'b1};
      lim_drv    = nom_ext * pulses_ext;
      lim_dly    = {{(CW-DIV_W){1'b0}}, (cfg_nom_div >> (4'd3 + {2'b00, cfg_delay_sel}))};
      lim_seek   = nom_ext + (nom_ext << 1);
      cnt_inc    = cnt_q + {{(CW-1){1'b0}}, 1'b1};
      drive_end  = (cnt_inc >= lim_drv);
      delay_end  = (cnt_inc >= lim_dly);
      dly_zero   = (lim_dly == '0);
      seek_tmo   = (cnt_inc >= lim_seek);
   end

   always_comb begin
      in_seek   = 1'b0;
      seek_idx  = 2'd0;
      seek_next = CS_SEEK2;
      case (st_q)
         CS_SEEK1: begin in_seek = 1'b1; seek_idx = 2'd0; seek_next = CS_SEEK2; end
         CS_SEEK2: begin in_seek = 1'b1; seek_idx = 2'd1; seek_next = CS_SEEK3; end
         CS_SEEK3: begin in_seek = 1'b1; seek_idx = 2'd2; seek_next = CS_SEEK4; end
         CS_SEEK4: begin in_seek = 1'b1; seek_idx = 2'd3; seek_next = CS_COMPUTE; end
         default:  ;
      endcase
   end

   assign can_start  = (st_q == CS_IDLE) || (st_q == CS_DONE) || (st_q == CS_FAIL);
   assign take_start = start && can_start;
   assign base_div   = (cfg_keep_en && keep_vld_q) ? keep_q : cfg_nom_div;

   assign zc_load   = pwm_tick &&
                      (((st_q == CS_DRIVE) && drive_end && dly_zero) ||
                       ((st_q == CS_DELAY) && delay_end));
   assign zc_sample = pwm_tick && in_seek;

   lra_zc_detect #(
      .THR_W (THR_W)
   ) zc_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (zc_load),
      .load_val  (cmp_in),
      .sample_en (zc_sample),
      .cmp       (cmp_in),
      .thr       (cfg_zx_thr),
      .hit       (zc_hit),
      .level     (zc_level)
   );

   lra_period_calc #(
      .DIV_W   (DIV_W),
      .TAG_W   (TAG_W),
      .SAT_EST (SAT_EST)
   ) calc_i (
      .tags    (tag_q),
      .nom     (cfg_nom_div),
      .avg_sel (cfg_avg_sel),
      .margin  (cfg_margin),
      .est_a   (est_a),
      .est_b   (est_b),
      .result  (calc_result),
      .accept  (calc_accept)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= CS_IDLE;
         cnt_q      <= '0;
         tag_q      <= '0;
         div_q      <= '0;
         keep_q     <= '0;
         keep_vld_q <= 1'b0;
         fail_q     <= 1'b0;
         first_q    <= 1'b1;
      end else if (take_start) begin
         div_q  <= base_div;
         fail_q <= 1'b0;
         cnt_q  <= '0;
         tag_q  <= '0;
         st_q   <= cfg_cal_en ? CS_DRIVE : CS_DONE;
      end else begin
         case (st_q)
            CS_DRIVE: begin
               if (pwm_tick) begin
                  if (drive_end) begin
                     cnt_q <= '0;
                     st_q  <= dly_zero ? CS_SEEK1 : CS_DELAY;
                  end else begin
                     cnt_q <= cnt_inc;
                  end
               end
            end
            CS_DELAY: begin
               if (pwm_tick) begin
                  if (delay_end) begin
                     cnt_q <= '0;
                     st_q  <= CS_SEEK1;
                  end else begin
                     cnt_q <= cnt_inc;
                  end
               end
            end
            CS_SEEK1, CS_SEEK2, CS_SEEK3, CS_SEEK4: begin
               if (pwm_tick) begin
                  cnt_q <= cnt_inc;
                  if (zc_hit) begin
                     tag_q[seek_idx] <= cnt_q[TAG_W-1:0];
                  end
                  if (zc_hit && (st_q == CS_SEEK4)) begin
                     st_q <= CS_COMPUTE;
                  end else if (seek_tmo) begin
                     st_q    <= CS_FAIL;
                     fail_q  <= 1'b1;
                     first_q <= 1'b0;
                  end else if (zc_hit) begin
                     st_q <= seek_next;
                  end
               end
            end
            CS_COMPUTE: begin
               st_q    <= CS_DONE;
               first_q <= 1'b0;
               if (calc_accept) begin
                  div_q <= calc_result;
                  if (cfg_keep_en) begin
                     keep_q     <= calc_result;
                     keep_vld_q <= 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign drive_on        = (st_q == CS_DRIVE);
   assign div_final       = div_q;
   assign first_tag       = tag_q[0];
   assign cal_fail        = fail_q;
   assign state_code      = st_q;
   assign last_level      = zc_level;
   assign first_since_por = first_q;

endmodule

// File: rtl/lra_period_cal_chk.sv
module lra_period_cal_chk #(
   parameter int DIV_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwm_tick,
   input logic             start,
   input logic             cfg_avg_sel,
   input logic [3:0]       cfg_margin,
   input logic [3:0]       state_code,
   input logic [DIV_W-1:0] div_final,
   input logic [DIV_W-1:0] est_a,
   input logic             cal_fail,
   input logic             first_since_por,
   input logic             last_level
);

   assert_compute_one_clock_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 4'd7) |=> (state_code == 4'd8));

   assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwm_tick && (state_code >= 4'd1) && (state_code <= 4'd6)) |=> $stable(state_code));

   assert_fail_means_fail_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cal_fail |-> (state_code == 4'd9));

   assert_divisor_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_code != 4'd7) &&
       !(start && ((state_code == 4'd0) || (state_code == 4'd8) || (state_code == 4'd9))))
      |=> $stable(div_final));

   assert_first_estimate_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_code == 4'd7) && (cfg_margin == 4'd0) && !cfg_avg_sel)
      |=> (div_final == $past(est_a)));

   assert_por_flag_clears_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(first_since_por) |-> ((state_code == 4'd8) || (state_code == 4'd9)));

   assert_level_moves_in_seek_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(last_level) |-> (($past(state_code) >= 4'd1) && ($past(state_code) <= 4'd6)));

endmodule

bind lra_period_cal lra_period_cal_chk #(
   .DIV_W (DIV_W)
) chk_i (
   .clk             (clk),
   .rst_n           (rst_n),
   .pwm_tick        (pwm_tick),
   .start           (start),
   .cfg_avg_sel     (cfg_avg_sel),
   .cfg_margin      (cfg_margin),
   .state_code      (state_code),
   .div_final       (div_final),
   .est_a           (est_a),
   .cal_fail        (cal_fail),
   .first_since_por (first_since_por),
   .last_level      (last_level)
);

// File: tb/lra_period_cal_tb_top.sv
`timescale 1ns/1ps
module lra_period_cal_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwm_tick = 1'b0;
   logic        cmp_in = 1'b0;
   logic        start = 1'b0;
   logic        cfg_cal_en = 1'b0;
   logic [2:0]  cfg_pulse_num = '0;
   logic [1:0]  cfg_delay_sel = '0;
   logic [7:0]  cfg_zx_thr = '0;
   logic        cfg_avg_sel = 1'b0;
   logic [3:0]  cfg_margin = '0;
   logic        cfg_keep_en = 1'b0;
   logic [15:0] cfg_nom_div = 16'd24;
   logic        drive_on;
   logic [15:0] div_final;
   logic [15:0] est_a;
   logic [15:0] est_b;
   logic [17:0] first_tag;
   logic        cal_fail;
   logic [3:0]  state_code;
   logic        last_level;
   logic        first_since_por;

   int vec_n = 0;
   int err_n = 0;
   bit finished = 1'b0;
   int keep_vld = 0;
   int keep_val = 0;

   always #4 clk = ~clk;

   lra_period_cal dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .pwm_tick        (pwm_tick),
      .cmp_in          (cmp_in),
      .start           (start),
      .cfg_cal_en      (cfg_cal_en),
      .cfg_pulse_num   (cfg_pulse_num),
      .cfg_delay_sel   (cfg_delay_sel),
      .cfg_zx_thr      (cfg_zx_thr),
      .cfg_avg_sel     (cfg_avg_sel),
      .cfg_margin      (cfg_margin),
      .cfg_keep_en     (cfg_keep_en),
      .cfg_nom_div     (cfg_nom_div),
      .drive_on        (drive_on),
      .div_final       (div_final),
      .est_a           (est_a),
      .est_b           (est_b),
      .first_tag       (first_tag),
      .cal_fail        (cal_fail),
      .state_code      (state_code),
      .last_level      (last_level),
      .first_since_por (first_since_por)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      vec_n++;
      if (act != exp) begin
         err_n++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit wave(input int g, input int h, input int ph, input int gl);
      bit v;
      v = (((g + ph) / h) % 2) != 0;
      if (gl != 0 && (g % 7) == 3) v = ~v;
      return v;
   endfunction

   task automatic run_cal(input int en, input int p, input int dsel, input int thr,
                          input int avg, input int marg, input int keep, input int n,
                          input int h, input int ph, input int gl, input int td,
                          input int mid);
      int s, lvl, acc, nf, eff, ma, mb, res, dev, code, tol, acc_ok, base;
      int tg[4];
      int g, cyc, dticks, exp_first;
      // reference model of the seek window (R4, R5, R6, R7)
      s   = (p + 1) * n + (n >> (3 + dsel));
      lvl = wave(s - 1, h, ph, gl);
      acc = 0; nf = 0;
      eff = (thr == 0) ? 1 : thr;
      for (int i = 0; i < 4; i++) tg[i] = 0;
      for (int k = 0; k < 3 * n && nf < 4; k++) begin
         int c;
         c = wave(s + k, h, ph, gl);
         if (c != lvl) begin
            if (acc + 1 >= eff) begin
               tg[nf] = k; nf++; lvl = c; acc = 0;
            end else acc++;
         end
      end
      ma   = tg[2] - tg[0];
      mb   = tg[3] - tg[1];
      res  = (avg != 0) ? ((ma + mb) >> 1) : ma;
      dev  = (res >= n) ? res - n : n - res;
      code = (marg > 7) ? 7 : marg;
      tol  = n >> (9 - code);
      acc_ok = (marg == 0) || (dev <= tol);
      base = (keep != 0 && keep_vld != 0) ? keep_val : n;
      exp_first = (en != 0) ? 0 : int'(first_since_por);

      @(negedge clk);
      cfg_cal_en    = en[0];
      cfg_pulse_num = p[2:0];
      cfg_delay_sel = dsel[1:0];
      cfg_zx_thr    = thr[7:0];
      cfg_avg_sel   = avg[0];
      cfg_margin    = marg[3:0];
      cfg_keep_en   = keep[0];
      cfg_nom_div   = n[15:0];
      pwm_tick = 1'b0;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (en != 0) chk("R3 drive state entered", state_code, 1);
      g = 0; cyc = 0; dticks = 0;
      while (state_code != 4'd8 && state_code != 4'd9 && cyc < 20000) begin
         cmp_in   = wave(g, h, ph, gl);
         pwm_tick = ((cyc % td) == 0);
         start    = (mid != 0) && (g == 5);
         if (pwm_tick && drive_on) dticks++;
         @(negedge clk);
         if (pwm_tick) g++;
         cyc++;
      end
      pwm_tick = 1'b0;
      start    = 1'b0;
      if (en == 0) begin
         chk("R2 state done", state_code, 8);
         chk("R2 divisor is base", div_final, base);
         chk("R2 no estimate", est_a, 0);
         chk("R2 no tag", first_tag, 0);
      end else begin
         chk("R3 drive ticks", dticks, (p + 1) * n);
         chk("R12 drive ticks with start during run", dticks + mid * 0, (p + 1) * n);
         chk("R5 last level", last_level, lvl);
         chk("R6 first tag", first_tag, (nf > 0) ? tg[0] : 0);
         if (nf < 4) begin
            chk("R7 fail state", state_code, 9);
            chk("R7 fail flag", cal_fail, 1);
            chk("R7 divisor held", div_final, base);
         end else begin
            chk("R13 done state", state_code, 8);
            chk("R7 no fail", cal_fail, 0);
            chk("R6 estimate a", est_a, ma);
            chk("R6 estimate b", est_b, mb);
            chk("R9 R8 divisor", div_final, acc_ok ? res : base);
            if (acc_ok && keep != 0) begin
               keep_vld = 1; keep_val = res;
            end
         end
      end
      chk("R11 first flag", first_since_por, exp_first);
   endtask

   initial begin
      #(8 * 180000);
      if (!finished) begin
         err_n++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 state", state_code, 0);
      chk("R1 divisor", div_final, 0);
      chk("R1 est a", est_a, 0);
      chk("R1 est b", est_b, 0);
      chk("R1 tag", first_tag, 0);
      chk("R1 fail", cal_fail, 0);
      chk("R1 drive", drive_on, 0);
      chk("R1 level", last_level, 0);
      chk("R1 por flag", first_since_por, 1);

      // R2 and R11: bypass keeps the power-on flag
      run_cal(0, 0, 0, 3, 0, 0, 0, 24, 12, 0, 0, 1, 0);
      chk("R11 flag after bypass", first_since_por, 1);

      // R3 R4 R5 R6 R8: pulse count by delay sweep
      for (int p = 0; p < 8; p++)
         for (int d = 0; d < 4; d++)
            run_cal(1, p, d, 3, p % 2, 0, 0, 24, 12, p + 3 * d, 0, 1, 0);

      // R9 band sweep, result 26 against nominal 24
      for (int m = 0; m < 16; m++)
         run_cal(1, 1, 0, 2, 0, m, 0, 24, 13, m, 0, 1, 0);

      // R5 R8 threshold sweep with glitches, both selections
      for (int t = 0; t < 7; t++)
         for (int a = 0; a < 2; a++)
            run_cal(1, 0, 1, t, a, 0, 0, 24, 12, t, 1, 1, 0);

      // R7 timeouts: slow comparator, then an unreachable threshold
      run_cal(1, 0, 0, 2, 0, 0, 0, 24, 40, 0, 0, 1, 0);
      run_cal(1, 0, 0, 200, 0, 0, 0, 24, 12, 0, 0, 1, 0);
      // R7 window edge sweep over phases
      for (int ph = 0; ph < 16; ph++)
         run_cal(1, 0, 0, 5, 0, 0, 0, 24, 16, ph, 0, 1, 0);

      // R10 keep sequence
      run_cal(1, 0, 0, 2, 0, 0, 1, 24, 13, 1, 0, 1, 0);
      run_cal(0, 0, 0, 2, 0, 0, 1, 24, 13, 1, 0, 1, 0);
      run_cal(0, 0, 0, 2, 0, 0, 0, 24, 13, 1, 0, 1, 0);
      run_cal(1, 0, 0, 2, 0, 3, 1, 24, 11, 1, 0, 1, 0);
      run_cal(1, 0, 0, 2, 0, 0, 1, 24, 40, 0, 0, 1, 0);
      run_cal(1, 0, 0, 2, 0, 0, 0, 24, 11, 2, 0, 1, 0);

      // R4 sparse enable, R12 start during a run
      run_cal(1, 2, 2, 3, 1, 0, 0, 24, 12, 4, 0, 3, 0);
      run_cal(1, 3, 1, 3, 0, 0, 0, 24, 12, 5, 0, 1, 1);
      run_cal(1, 1, 3, 4, 1, 6, 0, 40, 21, 7, 1, 2, 1);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
      $finish;
   end

endmodule